// File: doc/BRIEF.md
# Dual Reference Clock Selector

This block decides which of two reference clocks feeds a downstream PLL. It runs from a free-running local clock. It brings each reference's edges into that domain through a short synchronizer chain and watches each one with an edge watchdog. A reference turns invalid when its edges stop. It turns valid again after a run of good edge intervals. The block does not switch the clocks itself. It produces the select index that a separate glitch-free multiplexer acts on, a validity flag for each reference, a flag that shows both references are gone, and a one-cycle pulse for every change of the selection.

A two-bit policy field sets how the selection is made:

| Code | Policy | What decides the selection |
|------|--------|----------------------------|
| 00 | Manual, pin | An external select pin, passed through a synchronizer. |
| 01 | Automatic, non-revertive | Failover only; the block stays on the backup after the primary recovers. |
| 10 | Automatic, revertive | Failover, then a return to the primary as soon as it is valid. |
| 11 | Manual, register | A select bit. |

In the two automatic policies the same select bit names the primary reference and does not force the choice. Changing the policy or the primary makes the block look at the selection again on the next cycle. The reset is synchronous, so the first selection is taken from the inputs that are present while reset is held.

Top module: `refclk_chooser`

## Requirements
- R1: With policy 11, `active_o` equals the value `sel_bit_i` had one local-clock cycle earlier (0 picks reference 0, 1 picks reference 1), whatever the validity of the references.
- R2: With policy 00, `active_o` follows `sel_pin_i` after the synchronizer stages plus one register, and `sel_bit_i` has no effect on `active_o`.
- R3: `valid_o[i]` goes low once reference i shows no rising edge for `LOSS_CYCLES` local-clock cycles. It stays high while edges keep arriving at shorter intervals.
- R4: An invalid reference becomes valid again only after `RECOVER_EDGES` consecutive rising edges that follow a restart edge, with no gap of `LOSS_CYCLES` between them.
- R5: With policy 10, the selection moves to the primary named by `sel_bit_i` whenever the primary is valid. When the primary is invalid and the other reference is valid, the selection moves to the other reference.
- R6: With policy 01 and the policy and primary unchanged, the selection stays on a valid current reference, including a backup after the primary has recovered. It moves only when the current reference is invalid and the other one is valid.
- R7: In both automatic policies the selection never moves to an invalid reference. When both are invalid the selection is held, and `all_lost_o` is 1 exactly when `valid_o` is 00.
- R8: In an automatic policy, a change of the policy code or of `sel_bit_i` makes the block look at the selection again on the next cycle. It picks the primary if the primary is valid, otherwise the other reference if that one is valid, otherwise it holds the current selection.
- R9: `switch_o` is high for exactly the one cycle in which `active_o` shows a new value, and low in every other cycle.
- R10: When reset is released, `valid_o` is 00, `switch_o` is 0, and `active_o` equals the select bit (policies 01, 10 and 11) or the synchronized pin (policy 00) that was present while reset was held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running local clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ref0_i | input | 1 | Reference clock 0 (asynchronous) |
| ref1_i | input | 1 | Reference clock 1 (asynchronous) |
| policy_i | input | 2 | Selection policy: 00 pin, 01 auto non-revertive, 10 auto revertive, 11 register |
| sel_bit_i | input | 1 | Select bit (policy 11) or primary designation (policies 01 and 10) |
| sel_pin_i | input | 1 | External select pin, used with policy 00 (asynchronous) |
| active_o | output | 1 | Index of the selected reference |
| valid_o | output | 2 | Validity flag per reference; bit i is for reference i |
| switch_o | output | 1 | One-cycle pulse on each change of `active_o` |
| all_lost_o | output | 1 | High while both references are invalid |

## Verification
Some rules can be checked in every cycle, and these are covered by assertions:
- The register policy follows the select bit.
- The revertive policy follows a valid primary.
- The non-revertive policy holds while its current reference is valid.
- An automatic failover never lands on an invalid reference, and the selection holds when both references are lost.
- The switch pulse matches every change of the selection.
- The flags are in their reset state on release.

Other behaviour can only be shown by the bench's scenarios. These cover the timing of loss and recovery against edge streams that stop and restart, the pin path through its synchronizer, and the fact that the select bit is ignored in pin mode. They also cover failover sequences that depend on history, such as staying on the backup and then leaving it when the backup fails, and the selection that reset starts from under each policy.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

   typedef enum logic [1:0] {
      POL_PIN       = 2'b00,
      POL_AUTO_HOLD = 2'b01,
      POL_AUTO_BACK = 2'b10,
      POL_REG       = 2'b11
   } policy_e;

   localparam int unsigned NUM_REFS = 2;

endpackage

// File: rtl/refsel_sync.sv
// Synchronizer chain with no reset: it carries the input level while reset is held.
module refsel_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refsel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refsel_monitor.sv
// Edge watchdog for one reference that has already been synchronized.
module refsel_monitor #(
   parameter int unsigned LOSS_CYCLES   = 16,
   parameter int unsigned RECOVER_EDGES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic valid_o
);
   localparam int unsigned GAP_W  = $clog2(LOSS_CYCLES + 1);
   localparam int unsigned GOOD_W = $clog2(RECOVER_EDGES + 1);

   generate
      if (LOSS_CYCLES < 4) begin : g_bad_loss
         $error("refsel_monitor: LOSS_CYCLES must be at least 4");
      end
      if (RECOVER_EDGES < 1) begin : g_bad_recover
         $error("refsel_monitor: RECOVER_EDGES must be at least 1");
      end
   endgenerate

   logic              prev_q;
   logic              rise;
   logic              expired;
   logic [GAP_W-1:0]  gap_q;
   logic [GOOD_W-1:0] good_q;
   logic              valid_q;

   assign rise    = sig_i & ~prev_q;
   assign expired = (gap_q == GAP_W'(LOSS_CYCLES));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         gap_q   <= '0;
         good_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         prev_q <= sig_i;
         // count cycles since the last rising edge, saturating at the limit
         if (rise) begin
            gap_q <= '0;
         end else if (!expired) begin
            gap_q <= gap_q + 1'b1;
         end
         if (expired) begin
            // this edge, if there is one, only restarts the count
            valid_q <= 1'b0;
            good_q  <= '0;
         end else if (rise && !valid_q) begin
            if (good_q == GOOD_W'(RECOVER_EDGES - 1)) begin
               valid_q <= 1'b1;
               good_q  <= '0;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end
      end
   end

   assign valid_o = valid_q;
endmodule

// File: rtl/refsel_policy.sv
// Selection decision under the four policies.
module refsel_policy
   import refsel_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  policy_e    policy_i,
   input  logic       prim_i,
   input  logic       pin_i,
   input  logic [1:0] valid_i,
   output logic       active_o,
   output logic       switch_o
);
   policy_e pol_q;
   logic    prim_q;
   logic    active_q;
   logic    switch_q;
   logic    init_sel;
   logic    reeval;
   logic    pref;
   logic    nxt;

   assign init_sel = (policy_i == POL_PIN) ? pin_i : prim_i;
   assign reeval   = (policy_i != pol_q) || (prim_i != prim_q);

   // preferred choice: primary, else the other one, else keep the current one
   always_comb begin
      if (valid_i[prim_i]) begin
         pref = prim_i;
      end else if (valid_i[~prim_i]) begin
         pref = ~prim_i;
      end else begin
         pref = active_q;
      end
   end

   always_comb begin
      unique case (policy_i)
         POL_PIN:       nxt = pin_i;
         POL_REG:       nxt = prim_i;
         POL_AUTO_BACK: nxt = pref;
         POL_AUTO_HOLD: begin
            if (reeval) begin
               nxt = pref;
            end else if (valid_i[active_q]) begin
               nxt = active_q;
            end else if (valid_i[~active_q]) begin
               nxt = ~active_q;
            end else begin
               nxt = active_q;
            end
         end
         default:       nxt = active_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pol_q    <= policy_i;
         prim_q   <= prim_i;
         active_q <= init_sel;
         switch_q <= 1'b0;
      end else begin
         pol_q    <= policy_i;
         prim_q   <= prim_i;
         active_q <= nxt;
         switch_q <= (nxt != active_q);
      end
   end

   assign active_o = active_q;
   assign switch_o = switch_q;
endmodule

// File: rtl/refclk_chooser.sv
module refclk_chooser
   import refsel_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned LOSS_CYCLES   = 16,
   parameter int unsigned RECOVER_EDGES = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ref0_i,
   input  logic       ref1_i,
   input  logic [1:0] policy_i,
   input  logic       sel_bit_i,
   input  logic       sel_pin_i,
   output logic       active_o,
   output logic [1:0] valid_o,
   output logic       switch_o,
   output logic       all_lost_o
);
   logic [NUM_REFS-1:0] ref_raw;
   logic [NUM_REFS-1:0] ref_sync;
   logic [NUM_REFS-1:0] ref_valid;
   logic                pin_sync;

   assign ref_raw = {ref1_i, ref0_i};

   generate
      for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
         refsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i (clk_i),
            .d_i   (ref_raw[i]),
            .q_o   (ref_sync[i])
         );
         refsel_monitor #(
            .LOSS_CYCLES   (LOSS_CYCLES),
            .RECOVER_EDGES (RECOVER_EDGES)
         ) u_mon (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sig_i   (ref_sync[i]),
            .valid_o (ref_valid[i])
         );
      end
   endgenerate

   refsel_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i),
      .d_i   (sel_pin_i),
      .q_o   (pin_sync)
   );

   refsel_policy u_policy (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .policy_i (policy_e'(policy_i)),
      .prim_i   (sel_bit_i),
      .pin_i    (pin_sync),
      .valid_i  (ref_valid),
      .active_o (active_o),
      .switch_o (switch_o)
   );

   assign valid_o    = ref_valid;
   assign all_lost_o = ~|ref_valid;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] policy_i,
   input logic       sel_bit_i,
   input logic       active_o,
   input logic [1:0] valid_o,
   input logic       switch_o,
   input logic       all_lost_o
);
   logic       auto_mode;
   logic [1:0] valid_d;

   assign auto_mode = (policy_i == 2'b01) || (policy_i == 2'b10);

   always_ff @(posedge clk_i) begin
      valid_d <= valid_o;
   end

   p_reg_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'b11) |=> (active_o == $past(sel_bit_i)));

   p_revert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'b10 && valid_o[sel_bit_i]) |=> (active_o == $past(sel_bit_i)));

   p_nonrev_stay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'b01 && $stable(policy_i) && $stable(sel_bit_i) && valid_o[active_o])
      |=> $stable(active_o));

   p_to_valid_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_mode && valid_o != 2'b00) |=> valid_d[active_o]);

   p_hold_lost_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_mode && all_lost_o) |=> $stable(active_o));

   p_switch_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (switch_o == (active_o != $past(active_o))));

   p_reset_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (switch_o == 1'b0 && valid_o == 2'b00));
endmodule

bind refclk_chooser refsel_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .policy_i   (policy_i),
   .sel_bit_i  (sel_bit_i),
   .active_o   (active_o),
   .valid_o    (valid_o),
   .switch_o   (switch_o),
   .all_lost_o (all_lost_o)
);

// File: tb/sim_refclk_chooser.sv
`timescale 1ns/1ps
module sim_refclk_chooser;
   localparam int unsigned LOSS   = 16;
   localparam int unsigned RECOV  = 4;
   localparam int unsigned SETTLE = 100;
   localparam int unsigned NROWS  = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       r0 = 1'b0;
   logic       r1 = 1'b0;
   logic       en0 = 1'b0;
   logic       en1 = 1'b0;
   logic [1:0] pol = 2'b10;
   logic       sbit = 1'b0;
   logic       spin = 1'b0;
   logic       act;
   logic [1:0] vld;
   logic       sw;
   logic       lost;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   // ref0: edge every 4 local cycles; ref1: edge every 6
   initial forever begin #40; r0 = en0 ? ~r0 : 1'b0; end
   initial forever begin #60; r1 = en1 ? ~r1 : 1'b0; end

   refclk_chooser #(.SYNC_STAGES(2), .LOSS_CYCLES(LOSS), .RECOVER_EDGES(RECOV)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .ref0_i(r0), .ref1_i(r1),
      .policy_i(pol), .sel_bit_i(sbit), .sel_pin_i(spin),
      .active_o(act), .valid_o(vld), .switch_o(sw), .all_lost_o(lost));

   // row: {req[3:0], pol[1:0], bit, pin, en1, en0, exp_act, exp_v1, exp_v0}
   localparam logic [12:0] TBL [NROWS] = '{
      13'b0001_11_1_0_11_1_11,  // R1 register pick 1
      13'b0001_11_0_0_11_0_11,  // R1 register pick 0
      13'b0010_00_1_1_11_1_11,  // R2 pin 1
      13'b0010_00_0_1_11_1_11,  // R2 bit ignored in pin mode
      13'b0010_00_0_0_11_0_11,  // R2 pin 0
      13'b1000_10_1_0_11_1_11,  // R8 enter revertive, primary 1
      13'b0101_10_1_0_01_0_01,  // R5 primary lost, fail over
      13'b0101_10_1_0_11_1_11,  // R5 primary back, revert
      13'b1000_01_1_0_11_1_11,  // R8 enter non-revertive
      13'b0110_01_1_0_01_0_01,  // R6 primary lost, fail over
      13'b0110_01_1_0_11_0_11,  // R6 primary back, stay
      13'b0110_01_1_0_10_1_10,  // R6 backup lost, leave it
      13'b0111_01_1_0_00_1_00,  // R7 both lost, hold
      13'b0111_01_1_0_01_0_01,  // R7 ref0 back only
      13'b1000_01_0_0_11_0_11,  // R8 primary changed to 0
      13'b1000_01_1_0_11_1_11,  // R8 primary changed to 1
      13'b0001_11_0_0_00_0_00   // R1 register mode ignores validity
   };

   task automatic check(input bit ok, input string req, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic reset_check(input logic [1:0] p, input logic b, input logic pn, input logic exp_act);
      @(negedge clk);
      rst_n = 1'b0; pol = p; sbit = b; spin = pn; en0 = 1'b0; en1 = 1'b0;
      wait_cycles(6);
      rst_n = 1'b1;
      @(negedge clk);
      check(act == exp_act, "R10 active after reset", act, exp_act);
      check(vld == 2'b00 && sw == 1'b0 && lost == 1'b1, "R10 flags after reset",
            {vld, sw, lost}, 4'b0001);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R10: the starting selection under each policy
      reset_check(2'b10, 1'b1, 1'b0, 1'b1);
      reset_check(2'b01, 1'b0, 1'b1, 1'b0);
      reset_check(2'b00, 1'b1, 1'b1, 1'b1);
      reset_check(2'b11, 1'b0, 1'b1, 1'b0);

      // table walk
      for (int i = 0; i < NROWS; i++) begin
         logic [12:0] row;
         row = TBL[i];
         pol = row[8:7]; sbit = row[6]; spin = row[5]; en1 = row[4]; en0 = row[3];
         wait_cycles(SETTLE);
         check(act == row[2], $sformatf("R%0d row %0d active", row[12:9], i), act, row[2]);
         check(vld == row[1:0], $sformatf("R%0d row %0d valid", row[12:9], i), vld, row[1:0]);
         check(lost == (row[1:0] == 2'b00), $sformatf("R7 row %0d all_lost", i),
               lost, row[1:0] == 2'b00);
      end

      // R9: exact pulse timing in register mode
      pol = 2'b11; sbit = 1'b0; en0 = 1'b1; en1 = 1'b1;
      wait_cycles(10);
      sbit = 1'b1;
      @(posedge clk); #1;
      check(act == 1'b1 && sw == 1'b1, "R9 pulse with new index", {act, sw}, 2'b11);
      @(posedge clk); #1;
      check(sw == 1'b0, "R9 pulse lasts one cycle", sw, 0);
      begin
         int pulses;
         pulses = 0;
         @(negedge clk); sbit = 1'b0;
         for (int k = 0; k < 20; k++) begin @(negedge clk); pulses += sw; end
         check(pulses == 1, "R9 one pulse per change", pulses, 1);
      end

      // R3 and R4: loss and recovery windows for reference 0
      wait_cycles(SETTLE);
      en0 = 1'b0;
      wait_cycles(8);
      check(vld[0] == 1'b1, "R3 still valid before the gap ends", vld[0], 1);
      wait_cycles(22);
      check(vld[0] == 1'b0, "R3 invalid after the gap", vld[0], 0);
      en0 = 1'b1;
      wait_cycles(12);
      check(vld[0] == 1'b0, "R4 not valid before enough edges", vld[0], 0);
      wait_cycles(28);
      check(vld[0] == 1'b1, "R4 valid after good edges", vld[0], 1);

      // R2: pin path latency and the ignored select bit
      pol = 2'b00; spin = 1'b0; sbit = 1'b1;
      wait_cycles(10);
      check(act == 1'b0, "R2 bit ignored in pin mode", act, 0);
      spin = 1'b1;
      wait_cycles(1);
      check(act == 1'b0, "R2 pin not through synchronizer yet", act, 0);
      wait_cycles(3);
      check(act == 1'b1, "R2 pin followed", act, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule